// File: doc/BRIEF.md
# Bidirectional Pixel Window Shifter

This block holds a square neighbourhood of pixels, nine rows by nine columns of 8-bit values by default, for an adaptive median filter that grows its window from 3×3 up to 9×9 around one common centre. On each enabled clock the whole neighbourhood moves by one position in one of three directions. A fresh column can enter at the right edge while the contents slide left. A fresh column can enter at the left edge while the contents slide right. A fresh row can enter at the bottom while the contents slide up.

Horizontal moves serve a serpentine raster scan: the scan runs one way along an image row band and comes back the other way. When the scan turns at an image edge, the bottom-up move brings in one new row and keeps the other eight. Without it the window would have to be refilled from scratch. The complete window is presented as one flat vector, and the centre pixel has its own output, for the median and noise-decision logic that follows. That logic, line buffering and frame sequencing lie outside this block.

Internally each bit position of the pixel is a separate plane of single-bit cells. No plane shares logic with any other plane.

Top module: `pix_window_shifter`

## Requirements
- R1: When `rst` is high at a rising clock edge, every cell of the window becomes zero at that edge.
- R2: When `en` is low, every cell keeps its value whatever `up_sel`, `from_right`, `col_in` and `row_in` carry.
- R3: With `en` high and `up_sel` high, every row moves up one place and the top row is discarded. The new bottom row is taken from `row_in`, where byte c (bits [c*8 +: 8]) goes to column c.
- R4: With `en` high, `up_sel` low and `from_right` high, every column moves one place to the left and column 0 is discarded. The new rightmost column is taken from `col_in`, where byte r (bits [r*8 +: 8]) goes to row r.
- R5: With `en` high, `up_sel` low and `from_right` low, every column moves one place to the right and the rightmost column is discarded. The new column 0 is taken from `col_in`, where byte r goes to row r.
- R6: When `up_sel` and `from_right` are both high, the bottom-up move of R3 takes place and no horizontal move occurs.
- R7: `window_o` carries cell (row r, column c) at bits [(r*9+c)*8 +: 8]. Row 0 is the top row and column 0 is the leftmost column.
- R8: `centre_o` always equals the cell at row 4, column 4.
- R9: Bit k of every cell depends only on bit k of the inputs. Inputs that carry only one bit position leave every other bit of the window at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Enable for any move of the window |
| up_sel | input | 1 | Selects the bottom-up move; overrides `from_right` |
| from_right | input | 1 | 1: new column at the right edge, with a left shift; 0: new column at the left edge, with a right shift |
| col_in | input | 72 | New column, byte r for row r |
| row_in | input | 72 | New bottom row, byte c for column c |
| window_o | output | 648 | Whole window, flattened row by row from the top |
| centre_o | output | 8 | Centre pixel at row 4, column 4 |

## Verification
The hardest situation to reach from the ports is a window whose contents record a mixed history. Such a window holds pixels that arrived from both sides and through the bottom, and some of those pixels were then carried past the far edge and dropped. A wrong edge or a wrong discard shows up only there. The stimulus first drives directed sequences that fill the window in one direction and then reverse it. It then drives several hundred random mixes of left, right, bottom-up, both-controls and disabled cycles, each with random data, and compares every cell after every edge. A single-bit-plane phase drives inputs that carry only one bit position, to show that the planes do not leak into each other.

// File: rtl/pix_window_pkg.sv
package pix_window_pkg;

    // Move performed by the window on the next clock edge
    typedef enum logic [1:0] {
        MV_HOLD  = 2'd0,
        MV_LEFT  = 2'd1,   // new column enters on the right
        MV_RIGHT = 2'd2,   // new column enters on the left
        MV_UP    = 2'd3    // new row enters at the bottom
    } move_e;

endpackage

// File: rtl/pws_move_dec.sv
module pws_move_dec
    import pix_window_pkg::*;
(
    input  logic  en,
    input  logic  up_sel,
    input  logic  from_right,
    output move_e move_o
);

    always_comb begin
        if (!en)
            move_o = MV_HOLD;
        else if (up_sel)
            move_o = MV_UP;
        else if (from_right)
            move_o = MV_LEFT;
        else
            move_o = MV_RIGHT;
    end

endmodule

// File: rtl/pws_bit_plane.sv
module pws_bit_plane
    import pix_window_pkg::*;
#(
    parameter int ROWS = 9,
    parameter int COLS = 9
) (
    input  logic                 clk,
    input  logic                 rst,
    input  move_e                move_i,
    input  logic [ROWS-1:0]      col_bits_i,
    input  logic [COLS-1:0]      row_bits_i,
    output logic [ROWS*COLS-1:0] cells_o
);

    localparam int NCELL = ROWS * COLS;

    typedef struct packed {
        logic [NCELL-1:0] cells;
    } plane_t;

    plane_t plane_d, plane_q;

    always_comb begin
        plane_d = plane_q;
        unique case (move_i)
            MV_LEFT: begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int c = 0; c < COLS; c++) begin
                        if (c == COLS - 1)
                            plane_d.cells[r*COLS + c] = col_bits_i[r];
                        else
                            plane_d.cells[r*COLS + c] = plane_q.cells[r*COLS + c + 1];
                    end
                end
            end
            MV_RIGHT: begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int c = 0; c < COLS; c++) begin
                        if (c == 0)
                            plane_d.cells[r*COLS + c] = col_bits_i[r];
                        else
                            plane_d.cells[r*COLS + c] = plane_q.cells[r*COLS + c - 1];
                    end
                end
            end
            MV_UP: begin
                for (int r = 0; r < ROWS; r++) begin
                    for (int c = 0; c < COLS; c++) begin
                        if (r == ROWS - 1)
                            plane_d.cells[r*COLS + c] = row_bits_i[c];
                        else
                            plane_d.cells[r*COLS + c] = plane_q.cells[(r+1)*COLS + c];
                    end
                end
            end
            default: plane_d = plane_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            plane_q <= '0;
        else
            plane_q <= plane_d;
    end

    assign cells_o = plane_q.cells;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (plane_q.cells == '0));

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (move_i == MV_HOLD) |=> $stable(plane_q.cells));

    // R4
    left_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (move_i == MV_LEFT) |=> (plane_q.cells[COLS-1] == $past(col_bits_i[0]))
                             && (plane_q.cells[0] == $past(plane_q.cells[1])));

    // R5
    right_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (move_i == MV_RIGHT) |=> (plane_q.cells[0] == $past(col_bits_i[0]))
                              && (plane_q.cells[1] == $past(plane_q.cells[0])));

    // R3
    up_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (move_i == MV_UP) |=> (plane_q.cells[(ROWS-1)*COLS] == $past(row_bits_i[0]))
                           && (plane_q.cells[0] == $past(plane_q.cells[COLS])));

endmodule

// File: rtl/pix_window_shifter.sv
module pix_window_shifter
    import pix_window_pkg::*;
#(
    parameter int ROWS  = 9,
    parameter int COLS  = 9,
    parameter int PIX_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        en,
    input  logic                        up_sel,
    input  logic                        from_right,
    input  logic [ROWS*PIX_W-1:0]       col_in,
    input  logic [COLS*PIX_W-1:0]       row_in,
    output logic [ROWS*COLS*PIX_W-1:0]  window_o,
    output logic [PIX_W-1:0]            centre_o
);

    localparam int NCELL   = ROWS * COLS;
    localparam int MID_ROW = ROWS / 2;
    localparam int MID_COL = COLS / 2;
    localparam int MID_IDX = MID_ROW * COLS + MID_COL;

    move_e move;

    pws_move_dec u_dec (
        .en         (en),
        .up_sel     (up_sel),
        .from_right (from_right),
        .move_o     (move)
    );

    logic [NCELL-1:0] plane_cells [PIX_W];

    for (genvar b = 0; b < PIX_W; b++) begin : g_plane
        logic [ROWS-1:0] col_bits;
        logic [COLS-1:0] row_bits;

        for (genvar r = 0; r < ROWS; r++) begin : g_cb
            assign col_bits[r] = col_in[r*PIX_W + b];
        end
        for (genvar c = 0; c < COLS; c++) begin : g_rb
            assign row_bits[c] = row_in[c*PIX_W + b];
        end

        pws_bit_plane #(
            .ROWS (ROWS),
            .COLS (COLS)
        ) u_plane (
            .clk        (clk),
            .rst        (rst),
            .move_i     (move),
            .col_bits_i (col_bits),
            .row_bits_i (row_bits),
            .cells_o    (plane_cells[b])
        );

        for (genvar i = 0; i < NCELL; i++) begin : g_out
            assign window_o[i*PIX_W + b] = plane_cells[b][i];
        end
    end

    assign centre_o = window_o[MID_IDX*PIX_W +: PIX_W];

    // R6
    up_priority_chk: assert property (@(posedge clk) disable iff (rst)
        (en && up_sel && from_right) |=>
            (window_o[(ROWS-1)*COLS*PIX_W +: PIX_W] == $past(row_in[PIX_W-1:0])));

    // R2
    freeze_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(window_o));

    // R8
    centre_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (en && !up_sel && from_right) |=>
            (centre_o == $past(window_o[(MID_IDX+1)*PIX_W +: PIX_W])));

endmodule

// File: tb/pix_window_shifter_tb.sv
module pix_window_shifter_tb;

    localparam int ROWS  = 9;
    localparam int COLS  = 9;
    localparam int PIX_W = 8;
    localparam int WIN_W = ROWS*COLS*PIX_W;
    localparam int CW    = ROWS*PIX_W;
    localparam int RW    = COLS*PIX_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic             rst, en, up_sel, from_right;
    logic [CW-1:0]    col_in;
    logic [RW-1:0]    row_in;
    logic [WIN_W-1:0] window_o;
    logic [PIX_W-1:0] centre_o;

    pix_window_shifter #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PIX_W)) u_dut (
        .clk(clk), .rst(rst), .en(en), .up_sel(up_sel), .from_right(from_right),
        .col_in(col_in), .row_in(row_in), .window_o(window_o), .centre_o(centre_o)
    );

    logic [PIX_W-1:0] mdl [ROWS][COLS];
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    function automatic logic [WIN_W-1:0] mdl_flat();
        logic [WIN_W-1:0] res;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                res[(r*COLS+c)*PIX_W +: PIX_W] = mdl[r][c];
        return res;
    endfunction

    task automatic mdl_update();
        logic [PIX_W-1:0] old [ROWS][COLS];
        old = mdl;
        if (rst) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) mdl[r][c] = '0;
        end else if (en) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) begin
                    if (up_sel)
                        mdl[r][c] = (r == ROWS-1) ? row_in[c*PIX_W +: PIX_W] : old[r+1][c];
                    else if (from_right)
                        mdl[r][c] = (c == COLS-1) ? col_in[r*PIX_W +: PIX_W] : old[r][c+1];
                    else
                        mdl[r][c] = (c == 0) ? col_in[r*PIX_W +: PIX_W] : old[r][c-1];
                end
        end
    endtask

    task automatic check_win(string tag);
        logic [WIN_W-1:0] exp_w;
        exp_w = mdl_flat();
        checks++;
        if (window_o !== exp_w) begin
            fails++;
            $display("FAIL %s window: got %h expected %h", tag, window_o, exp_w);
        end
        checks++;
        if (centre_o !== mdl[ROWS/2][COLS/2]) begin
            fails++;
            $display("FAIL R8 centre: got %h expected %h", centre_o, mdl[ROWS/2][COLS/2]);
        end
    endtask

    // called at a falling edge; returns at the next falling edge after checking
    task automatic step(input logic e, input logic u, input logic fr,
                        input logic [CW-1:0] ci, input logic [RW-1:0] ri, input string tag);
        en = e; up_sel = u; from_right = fr; col_in = ci; row_in = ri;
        @(posedge clk);
        mdl_update();
        @(negedge clk);
        check_win(tag);
    endtask

    function automatic logic [CW-1:0] rnd72();
        return {$urandom, $urandom, $urandom};
    endfunction

    function automatic logic [CW-1:0] seq_bytes(input int base);
        logic [CW-1:0] v;
        for (int i = 0; i < 9; i++) v[i*8 +: 8] = 8'(base + i);
        return v;
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        logic [CW-1:0] mask;
        seed_dummy = $urandom(32'd1357);
        rst = 1; en = 1; up_sel = 0; from_right = 1; col_in = '1; row_in = '1;
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++) mdl[r][c] = 'x;
        @(negedge clk);
        step(1, 1, 1, '1, '1, "R1 reset");
        rst = 0;

        // R7: single bottom-up fill, bytes land at bottom row positions
        step(1, 1, 0, '0, seq_bytes(1), "R7 layout");
        step(1, 1, 0, '0, seq_bytes(16), "R3 up");
        // R4: left shifts with column from right
        for (int i = 0; i < 9; i++) step(1, 0, 1, seq_bytes(32 + 9*i), rnd72(), "R4 left");
        // R5: reverse direction
        for (int i = 0; i < 4; i++) step(1, 0, 0, seq_bytes(128 + 9*i), rnd72(), "R5 right");
        // R6: both controls high
        step(1, 1, 1, rnd72(), seq_bytes(200), "R6 priority");
        // R2: disabled under every control mix
        for (int i = 0; i < 4; i++) step(0, i[1], i[0], rnd72(), rnd72(), "R2 hold");
        step(1, 1, 0, rnd72(), rnd72(), "R3 up");

        // R9: only bit 5 driven
        step(1, 1, 1, '1, '1, "R1 reset");
        rst = 1;
        step(1, 0, 0, '0, '0, "R1 reset");
        rst = 0;
        mask = {9{8'h20}};
        for (int i = 0; i < 30; i++) begin
            step(1, ($urandom % 3) == 0, $urandom % 2, rnd72() & mask, rnd72() & mask, "R9 plane");
            checks++;
            if ((window_o & ~{81{8'h20}}) !== '0) begin
                fails++;
                $display("FAIL R9 leak: got %h expected only bit 5 set", window_o);
            end
        end

        // random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom % 8;
            case (k)
                0:       step(0, $urandom % 2, $urandom % 2, rnd72(), rnd72(), "R2 hold");
                1, 2:    step(1, 1, $urandom % 2, rnd72(), rnd72(), "R3 up");
                3, 4:    step(1, 0, 1, rnd72(), rnd72(), "R4 left");
                default: step(1, 0, 0, rnd72(), rnd72(), "R5 right");
            endcase
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule